// File: doc/BRIEF.md
# Link Power State Controller

This block is the state machine that keeps track of, and moves between, the power states of one end of a serial point-to-point link. It follows six link states: fully active, a quick standby in which only the local transmitter idles, a doze state in which both directions idle, a pre-power-off waiting state, an auxiliary-power sleep that can be woken, and a full power-off state. The link state is tied to the device power state (D0, D1, D2, D3hot, D3cold). When the device leaves D0, the link is sent to doze. When the device is in D0 and power management is enabled, an idle timer moves the link into standby and then into doze.

Software can ask for a given link state with a one-cycle request strobe. The request is checked against a table of link states allowed for the present device state, and against the legal moves out of the present link state. A refused request leaves the state where it is and sets a sticky error flag. The request strobe has no back-pressure: it is judged in the cycle it is presented, and any result is visible one cycle later. Leaving the sleep states works differently for each. The auxiliary-power sleep raises a wake request when the wake input is asserted. The power-off state has no exit except the fundamental reset, which returns the link to active from any state within one clock.

Top module: `lnk_pwr_ctrl`

## Requirements
- R1: After `rst_n` is released, `link_state` is 0 (active) and `tx_eidle`, `aux_only`, `wake_out` and `req_err` are all 0.
- R2: In active state with device D0, `pm_en` high and no request, each cycle with `traffic` low advances an idle count. The link enters standby (code 1) on the S_IDLE-th such cycle. A cycle with `traffic` high restarts the count. With `pm_en` low the link stays active.
- R3: In standby, the first cycle that samples `traffic` high starts a recovery. The link stays in standby for EXIT_CYC more cycles and then returns to active (code 0), whether or not traffic stays high.
- R4: With ASPM_L1 set, an idle count that keeps running through standby moves the link to doze (code 2) on the D_IDLE-th idle cycle counted from the start of the count.
- R5: A device state other than D0 (dev codes 1=D1, 2=D2, 3=D3hot, 4=D3cold) moves an active or standby link to doze on the next edge. Doze entered under D0 is left for active on a cycle with `traffic` high. Doze entered under another device state is left for active once the device state is D0 again. Outside D0, traffic is ignored.
- R6: A request is accepted only if its target is allowed for the device state. D0 allows codes 0, 1 and (with ASPM_L1) 2. D1 and D2 allow 2. D3hot allows 2 and 3. D3cold allows 4 and 5. A refused request leaves `link_state` unchanged and sets `req_err`, which stays set until the fundamental reset.
- R7: Pre-power-off (code 3) is entered only from doze. From code 3 the only moves are to auxiliary sleep (code 4) or power-off (code 5). A request back to doze from code 3 is refused.
- R8: In auxiliary sleep, `wake_in` high sets `wake_out` on the next edge. `wake_out` and the state then hold until the fundamental reset. In power-off (code 5), `wake_in` is ignored and `wake_out` stays 0.
- R9: `fund_rst` high moves the link to active on the next edge from any state, clears `req_err` and `wake_out`, and wins over a request in the same cycle.
- R10: `tx_eidle` is 1 in every state except active. `rx_eidle` follows `peer_idle` in active and standby and is 1 in all other states. `aux_only` is 1 only in auxiliary sleep.
- R11: When a request and an idle-timer expiry fall in the same cycle, the request decides the next state and the idle count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fund_rst | input | 1 | Fundamental reset, synchronous, forces the active state |
| dev_state | input | 3 | Device power state: 0=D0, 1=D1, 2=D2, 3=D3hot, 4=D3cold |
| pm_en | input | 1 | Active-state power management enable |
| traffic | input | 1 | Pending traffic / link activity |
| peer_idle | input | 1 | Remote transmitter is idle |
| req_valid | input | 1 | Software link-state request strobe |
| req_state | input | 3 | Requested link state code |
| wake_in | input | 1 | External wake event |
| link_state | output | 3 | Current link state: 0 active, 1 standby, 2 doze, 3 pre-off, 4 aux sleep, 5 off |
| tx_eidle | output | 1 | Local transmitter in electrical idle |
| rx_eidle | output | 1 | Local receiver in electrical idle |
| aux_only | output | 1 | Only auxiliary power in use |
| wake_out | output | 1 | Wake request toward the system |
| req_err | output | 1 | Sticky flag for a refused request |

## Verification
Two collisions matter most. The first is a software request that lands in the very cycle the idle timer would expire: the bench runs the idle count to one short of the threshold, strobes a request for the active state in the next cycle, and expects the link to stay active and then need a full S_IDLE idle cycles before it enters standby. The second is a fundamental reset that arrives together with a request the table would refuse: the bench expects the active state with the error flag clear, because the reset wins. The expected states are pushed into a scoreboard queue by the driver and compared by a monitor half a cycle after each edge.

// File: rtl/lnk_pwr_pkg.sv
package lnk_pwr_pkg;

  typedef enum logic [2:0] {
    LK_ON     = 3'd0,
    LK_QUICK  = 3'd1,
    LK_DOZE   = 3'd2,
    LK_PREOFF = 3'd3,
    LK_AUX    = 3'd4,
    LK_OFF    = 3'd5
  } lk_state_e;

  typedef enum logic [2:0] {
    DV_D0     = 3'd0,
    DV_D1     = 3'd1,
    DV_D2     = 3'd2,
    DV_D3HOT  = 3'd3,
    DV_D3COLD = 3'd4
  } dv_state_e;

  localparam int unsigned LK_CODES = 8;

  // Link states permitted for a device state.
  function automatic logic in_table(input logic [2:0] dv, input logic [2:0] tgt,
                                    input logic l1_opt);
    logic r;
    r = 1'b0;
    case (dv)
      3'd0: r = (tgt == 3'd0) || (tgt == 3'd1) || ((tgt == 3'd2) && l1_opt);
      3'd1,
      3'd2: r = (tgt == 3'd2);
      3'd3: r = (tgt == 3'd2) || (tgt == 3'd3);
      3'd4: r = (tgt == 3'd4) || (tgt == 3'd5);
      default: r = 1'b0;
    endcase
    return r;
  endfunction

  // Moves a request may cause from the present link state.
  function automatic logic edge_ok(input logic [2:0] cur, input logic [2:0] tgt);
    logic r;
    r = (cur == tgt);
    case (cur)
      3'd0: r = r || (tgt == 3'd1) || (tgt == 3'd2);
      3'd1: r = r || (tgt == 3'd0) || (tgt == 3'd2);
      3'd2: r = r || (tgt == 3'd0) || (tgt == 3'd3);
      3'd3: r = r || (tgt == 3'd4) || (tgt == 3'd5);
      default: r = r;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lnk_idle_tmr.sv
module lnk_idle_tmr #(
  parameter int unsigned S_IDLE = 64,
  parameter int unsigned D_IDLE = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic hit_quick,
  output logic hit_doze
);
  localparam int unsigned CW = $clog2(D_IDLE + 1);
  localparam logic [CW-1:0] QUICK_AT = CW'(S_IDLE - 1);
  localparam logic [CW-1:0] DOZE_AT  = CW'(D_IDLE - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else if (cnt != DOZE_AT) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign hit_quick = run && (cnt == QUICK_AT);
  assign hit_doze  = run && (cnt == DOZE_AT);

  // R2: any cycle without idle qualification restarts the count
  a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);

  // R4: the count never passes the doze threshold
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= DOZE_AT);

endmodule

// File: rtl/lnk_exit_rec.sv
module lnk_exit_rec #(
  parameter int unsigned EXIT_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic clr,
  output logic busy,
  output logic done
);
  localparam int unsigned CW = $clog2(EXIT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(EXIT_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (clr) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end
  end

  assign done = busy && (cnt == LAST);

  // R3: recovery count stays inside its window
  a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt <= LAST);

  // R3: once begun, recovery is not abandoned unless cleared
  a_r3_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !clr && !done) |=> busy);

endmodule

// File: rtl/lnk_allow_chk.sv
module lnk_allow_chk
  import lnk_pwr_pkg::*;
#(
  parameter bit ASPM_L1 = 1'b1
) (
  input  logic [2:0] dev,
  input  logic [2:0] cur,
  input  logic [2:0] tgt,
  output logic       ok
);
  logic [LK_CODES-1:0] tbl;

  for (genvar s = 0; s < LK_CODES; s++) begin : g_tbl
    assign tbl[s] = in_table(dev, 3'(s), ASPM_L1) && edge_ok(cur, 3'(s));
  end

  assign ok = tbl[tgt];

  // R7: no accepted request reaches pre-off from anywhere but doze
  always_comb begin
    if (ok && (tgt == 3'd3))
      a_r7_preoff_src: assert (cur == 3'd2 || cur == 3'd3);
  end

endmodule

// File: rtl/lnk_pwr_ctrl.sv
module lnk_pwr_ctrl
  import lnk_pwr_pkg::*;
#(
  parameter int unsigned S_IDLE   = 64,
  parameter int unsigned D_IDLE   = 256,
  parameter int unsigned EXIT_CYC = 16,
  parameter bit          ASPM_L1  = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fund_rst,
  input  logic [2:0] dev_state,
  input  logic       pm_en,
  input  logic       traffic,
  input  logic       peer_idle,
  input  logic       req_valid,
  input  logic [2:0] req_state,
  input  logic       wake_in,
  output logic [2:0] link_state,
  output logic       tx_eidle,
  output logic       rx_eidle,
  output logic       aux_only,
  output logic       wake_out,
  output logic       req_err
);

  lk_state_e st, st_nxt;
  logic      doze_tf, doze_tf_nxt;
  logic      err_q, wake_q;
  logic      err_set;
  logic      dev_d0;
  logic      tmr_run, hit_quick, hit_doze;
  logic      rec_start, rec_clr, rec_busy, rec_done;
  logic      req_ok;

  assign dev_d0 = (dev_state == DV_D0);

  assign tmr_run = pm_en && !traffic && !fund_rst && !req_valid && dev_d0 &&
                   ((st == LK_ON) || ((st == LK_QUICK) && !rec_busy));

  lnk_idle_tmr #(
    .S_IDLE (S_IDLE),
    .D_IDLE (D_IDLE)
  ) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (tmr_run),
    .hit_quick (hit_quick),
    .hit_doze  (hit_doze)
  );

  assign rec_start = (st == LK_QUICK) && traffic;
  assign rec_clr   = (st_nxt != LK_QUICK);

  lnk_exit_rec #(
    .EXIT_CYC (EXIT_CYC)
  ) u_rec (
    .clk   (clk),
    .rst_n (rst_n),
    .start (rec_start),
    .clr   (rec_clr),
    .busy  (rec_busy),
    .done  (rec_done)
  );

  lnk_allow_chk #(
    .ASPM_L1 (ASPM_L1)
  ) u_chk (
    .dev (dev_state),
    .cur (st),
    .tgt (req_state),
    .ok  (req_ok)
  );

  // Next state: reset, then request, then automatic moves.
  always_comb begin
    st_nxt      = st;
    err_set     = 1'b0;
    doze_tf_nxt = doze_tf;
    if (fund_rst) begin
      st_nxt = LK_ON;
    end else if (req_valid) begin
      if (req_ok) st_nxt = lk_state_e'(req_state);
      else        err_set = 1'b1;
    end else begin
      case (st)
        LK_ON: begin
          if (!dev_d0)        st_nxt = LK_DOZE;
          else if (hit_quick) st_nxt = LK_QUICK;
        end
        LK_QUICK: begin
          if (!dev_d0)                  st_nxt = LK_DOZE;
          else if (rec_done)            st_nxt = LK_ON;
          else if (hit_doze && ASPM_L1) st_nxt = LK_DOZE;
        end
        LK_DOZE: begin
          if (dev_d0 && (traffic || !doze_tf)) st_nxt = LK_ON;
        end
        default: st_nxt = st;
      endcase
    end
    if ((st_nxt == LK_DOZE) && (st != LK_DOZE))
      doze_tf_nxt = dev_d0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= LK_ON;
      doze_tf <= 1'b0;
      err_q   <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      st      <= st_nxt;
      doze_tf <= doze_tf_nxt;
      if (fund_rst)     err_q <= 1'b0;
      else if (err_set) err_q <= 1'b1;
      if (fund_rst)                        wake_q <= 1'b0;
      else if ((st == LK_AUX) && wake_in)  wake_q <= 1'b1;
    end
  end

  assign link_state = st;
  assign tx_eidle   = (st != LK_ON);
  assign rx_eidle   = ((st == LK_ON) || (st == LK_QUICK)) ? peer_idle : 1'b1;
  assign aux_only   = (st == LK_AUX);
  assign wake_out   = wake_q;
  assign req_err    = err_q;

  // R9: fundamental reset returns the link to active and clears flags
  a_r9_fund_rst_on: assert property (@(posedge clk) disable iff (!rst_n)
    fund_rst |=> (link_state == 3'd0) && !req_err && !wake_out);

  // R6: error flag is sticky until the fundamental reset
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (req_err && !fund_rst) |=> req_err);

  // R6: a refused request leaves the state alone
  a_r6_refused_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ok && !fund_rst) |=> $stable(link_state));

  // R7: pre-off is only entered from doze
  a_r7_preoff_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == 3'd3 && $past(link_state) != 3'd3) |-> $past(link_state) == 3'd2);

  // R7: pre-off never falls back without the fundamental reset
  a_r7_preoff_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == 3'd3 && !fund_rst) |=> (link_state == 3'd3 || link_state == 3'd4 ||
                                           link_state == 3'd5));

  // R8: auxiliary sleep is only left through the fundamental reset
  a_r8_aux_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == 3'd4 && !fund_rst) |=> link_state == 3'd4);

  // R8: power-off never raises a wake request
  a_r8_off_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == 3'd5) |-> !wake_out);

  // R5: leaving D0 takes an active or standby link to doze
  a_r5_leave_d0: assert property (@(posedge clk) disable iff (!rst_n)
    ((link_state == 3'd0 || link_state == 3'd1) && dev_state != 3'd0 &&
     !fund_rst && !req_valid) |=> link_state == 3'd2);

endmodule

// File: tb/lnk_pwr_ctrl_bench.sv
module lnk_pwr_ctrl_bench;

  localparam int unsigned S_IDLE   = 8;
  localparam int unsigned D_IDLE   = 20;
  localparam int unsigned EXIT_CYC = 4;

  localparam logic [2:0] S_ON = 3'd0, S_QK = 3'd1, S_DZ = 3'd2,
                         S_PO = 3'd3, S_AX = 3'd4, S_OF = 3'd5;
  localparam logic [2:0] V_D0 = 3'd0, V_D1 = 3'd1, V_D3H = 3'd3, V_D3C = 3'd4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fund_rst = 1'b0;
  logic [2:0] dev_state = 3'd0;
  logic       pm_en = 1'b0;
  logic       traffic = 1'b0;
  logic       peer_idle = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_state = 3'd0;
  logic       wake_in = 1'b0;
  logic [2:0] link_state;
  logic       tx_eidle, rx_eidle, aux_only, wake_out, req_err;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  lnk_pwr_ctrl #(
    .S_IDLE   (S_IDLE),
    .D_IDLE   (D_IDLE),
    .EXIT_CYC (EXIT_CYC),
    .ASPM_L1  (1'b1)
  ) u_lnk_pwr_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .fund_rst   (fund_rst),
    .dev_state  (dev_state),
    .pm_en      (pm_en),
    .traffic    (traffic),
    .peer_idle  (peer_idle),
    .req_valid  (req_valid),
    .req_state  (req_state),
    .wake_in    (wake_in),
    .link_state (link_state),
    .tx_eidle   (tx_eidle),
    .rx_eidle   (rx_eidle),
    .aux_only   (aux_only),
    .wake_out   (wake_out),
    .req_err    (req_err)
  );

  typedef struct {
    string      tag;
    logic [2:0] st;
    logic       err;
    logic       wk;
  } exp_t;

  exp_t sb[$];

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic expect_st(input string tag, input logic [2:0] st,
                           input logic err, input logic wk);
    exp_t e;
    e.tag = tag; e.st = st; e.err = err; e.wk = wk;
    sb.push_back(e);
  endtask

  task automatic request(input logic [2:0] s);
    req_valid = 1'b1;
    req_state = s;
    tick(1);
    req_valid = 1'b0;
  endtask

  // Monitor: compare every queued expectation half a cycle after the edge.
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        exp_t e;
        logic etx, erx, eax;
        e   = sb.pop_front();
        etx = (e.st != S_ON);
        erx = (e.st == S_ON || e.st == S_QK) ? peer_idle : 1'b1;
        eax = (e.st == S_AX);
        total++;
        if (link_state !== e.st || tx_eidle !== etx || rx_eidle !== erx ||
            aux_only !== eax || req_err !== e.err || wake_out !== e.wk) begin
          bad++;
          $display("FAIL %s: got st=%0d tx=%b rx=%b aux=%b err=%b wake=%b exp st=%0d tx=%b rx=%b aux=%b err=%b wake=%b",
                   e.tag, link_state, tx_eidle, rx_eidle, aux_only, req_err, wake_out,
                   e.st, etx, erx, eax, e.err, e.wk);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    expect_st("R1 reset state", S_ON, 1'b0, 1'b0);

    // R2 / R10: power management off keeps the link active
    peer_idle = 1'b1;
    tick(30);
    expect_st("R2 pm_en low stays active (R10 rx follows peer)", S_ON, 1'b0, 1'b0);

    // R2: idle count to standby
    peer_idle = 1'b0;
    pm_en = 1'b1;
    tick(S_IDLE - 1);
    expect_st("R2 one short of idle threshold", S_ON, 1'b0, 1'b0);
    tick(1);
    expect_st("R2 enter standby", S_QK, 1'b0, 1'b0);
    peer_idle = 1'b1;
    tick(1);
    expect_st("R10 standby rx follows peer", S_QK, 1'b0, 1'b0);

    // R3: recovery from standby
    traffic = 1'b1;
    tick(1);
    traffic = 1'b0;
    tick(EXIT_CYC - 1);
    expect_st("R3 still recovering", S_QK, 1'b0, 1'b0);
    tick(1);
    expect_st("R3 back to active", S_ON, 1'b0, 1'b0);

    // R2: traffic restarts the idle count
    peer_idle = 1'b0;
    tick(5);
    traffic = 1'b1;
    tick(1);
    traffic = 1'b0;
    tick(S_IDLE - 1);
    expect_st("R2 count restarted by traffic", S_ON, 1'b0, 1'b0);
    tick(1);
    expect_st("R2 standby after restart", S_QK, 1'b0, 1'b0);

    // R4: continued idle goes to doze
    tick(D_IDLE - S_IDLE - 1);
    expect_st("R4 one short of doze threshold", S_QK, 1'b0, 1'b0);
    tick(1);
    expect_st("R4 enter doze", S_DZ, 1'b0, 1'b0);

    // R5: doze entered under D0 leaves on traffic
    tick(3);
    expect_st("R5 doze holds without traffic", S_DZ, 1'b0, 1'b0);
    traffic = 1'b1;
    tick(1);
    traffic = 1'b0;
    expect_st("R5 traffic wakes doze", S_ON, 1'b0, 1'b0);

    // R5: device state change forces doze, traffic ignored outside D0
    pm_en = 1'b0;
    dev_state = V_D1;
    tick(1);
    expect_st("R5 D1 forces doze", S_DZ, 1'b0, 1'b0);
    traffic = 1'b1;
    tick(2);
    traffic = 1'b0;
    expect_st("R5 traffic ignored in D1", S_DZ, 1'b0, 1'b0);

    // R6: refused request
    request(S_ON);
    expect_st("R6 active refused in D1", S_DZ, 1'b1, 1'b0);
    tick(3);
    expect_st("R6 error sticky", S_DZ, 1'b1, 1'b0);

    // R9: fundamental reset
    fund_rst = 1'b1;
    tick(1);
    fund_rst = 1'b0;
    dev_state = V_D3H;
    expect_st("R9 reset to active, error cleared", S_ON, 1'b0, 1'b0);
    tick(1);
    expect_st("R5 D3hot forces doze", S_DZ, 1'b0, 1'b0);
    request(S_AX);
    expect_st("R6 aux sleep refused in D3hot", S_DZ, 1'b1, 1'b0);
    fund_rst = 1'b1;
    tick(1);
    fund_rst = 1'b0;
    expect_st("R9 reset clears error", S_ON, 1'b0, 1'b0);
    tick(1);
    expect_st("R5 doze again", S_DZ, 1'b0, 1'b0);

    // R7: pre-off sequencing
    request(S_PO);
    expect_st("R7 pre-off from doze", S_PO, 1'b0, 1'b0);
    request(S_DZ);
    expect_st("R7 no return to doze", S_PO, 1'b1, 1'b0);
    dev_state = V_D3C;
    request(S_AX);
    expect_st("R7 pre-off to aux sleep", S_AX, 1'b1, 1'b0);

    // R8: wake in auxiliary sleep
    tick(2);
    expect_st("R8 aux sleep no wake yet", S_AX, 1'b1, 1'b0);
    wake_in = 1'b1;
    tick(1);
    wake_in = 1'b0;
    expect_st("R8 wake raised", S_AX, 1'b1, 1'b1);
    tick(2);
    expect_st("R8 wake held, state held", S_AX, 1'b1, 1'b1);
    request(S_ON);
    expect_st("R8 request cannot leave aux sleep", S_AX, 1'b1, 1'b1);

    dev_state = V_D3H;
    fund_rst = 1'b1;
    tick(1);
    fund_rst = 1'b0;
    expect_st("R9 reset leaves aux sleep, clears wake", S_ON, 1'b0, 1'b0);
    tick(1);
    request(S_PO);
    dev_state = V_D3C;
    request(S_OF);
    expect_st("R7 pre-off to power-off", S_OF, 1'b0, 1'b0);
    wake_in = 1'b1;
    tick(2);
    wake_in = 1'b0;
    expect_st("R8 power-off ignores wake", S_OF, 1'b0, 1'b0);
    request(S_AX);
    expect_st("R6 off to aux refused", S_OF, 1'b1, 1'b0);

    // R9: reset wins over a request in the same cycle
    dev_state = V_D0;
    fund_rst = 1'b1;
    req_valid = 1'b1;
    req_state = S_AX;
    tick(1);
    fund_rst = 1'b0;
    req_valid = 1'b0;
    expect_st("R9 reset beats request", S_ON, 1'b0, 1'b0);

    // R11: request collides with timer expiry
    pm_en = 1'b1;
    tick(S_IDLE - 1);
    expect_st("R11 at expiry edge", S_ON, 1'b0, 1'b0);
    request(S_ON);
    expect_st("R11 request wins over expiry", S_ON, 1'b0, 1'b0);
    tick(S_IDLE - 1);
    expect_st("R11 count restarted", S_ON, 1'b0, 1'b0);
    tick(1);
    expect_st("R11 standby after full count", S_QK, 1'b0, 1'b0);

    // R6: D0 allows doze by request; exit on traffic
    pm_en = 1'b0;
    request(S_DZ);
    expect_st("R6 doze accepted in D0", S_DZ, 1'b0, 1'b0);
    tick(2);
    expect_st("R5 requested doze in D0 waits for traffic", S_DZ, 1'b0, 1'b0);
    traffic = 1'b1;
    tick(1);
    traffic = 1'b0;
    expect_st("R5 traffic ends doze", S_ON, 1'b0, 1'b0);

    tick(2);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule